// File: doc/BRIEF.md
# Receive DC Offset Corrector

This block strips the DC component from a complex receive stream. The I and Q rails each have their own corrector. A corrector either tracks the mean of its rail with a leaky integrator or holds an offset. The held offset is either the estimate the integrator reached last or a value written by software. The corrected sample is the input minus the current offset, clamped to the signed 16-bit range. It leaves a register that is aligned to the input valid strobe.

Each rail has one 32-bit control word, written over a simple write-only register bus. Two flag bits sit at the top of the word: a fixed flag and a set flag. The low 30 bits carry a signed offset, on a scale where 2^29 stands for one full-scale unit.

Top module: `rx_dc_corrector`

## Requirements
- R1: After reset both rails are in tracking mode with an estimate of zero, `out_valid` is 0 and both outputs are 0, so the first valid sample leaves unchanged.
- R2: Each sample accepted with `in_valid` high appears on `out_i`/`out_q` with `out_valid` high exactly one clock later, and `out_valid` is low one clock after a cycle with `in_valid` low.
- R3: The output is input minus offset, saturated to [-32768, 32767] rather than wrapped.
- R4: The estimate is 30-bit signed, where 2^29 means full scale. The offset applied is the estimate shifted arithmetically right by 14 (floor). In tracking mode each valid sample updates the estimate to est + ((x*2^14 - est) >>> 12), and the current sample is corrected with the estimate from before this update.
- R5: A write with bit 31 clear selects tracking mode. Bit 30 and bits 29:0 are ignored, and tracking resumes from the current estimate.
- R6: A write with bit 31 set and bit 30 clear freezes the current estimate, which then stays constant whatever samples arrive.
- R7: A write with bits 31 and 30 both set loads bits 29:0, as a signed value, as the estimate and freezes it.
- R8: The I rail's word is at byte address 8 and the Q rail's at byte address 12. A write to any other address changes neither rail, and a write to one rail leaves the other untouched.
- R9: When a register write and a valid sample hit the same rail in the same cycle, the sample is corrected with the old offset, and the write's result replaces that cycle's tracking update.
- R10: A cycle with `in_valid` low leaves the estimate unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Byte address of the write |
| reg_wdata | input | 32 | Write data: bit 31 fixed, bit 30 set, 29:0 offset |
| in_valid | input | 1 | Input sample strobe |
| in_i | input | 16 | Input I sample, signed |
| in_q | input | 16 | Input Q sample, signed |
| out_valid | output | 1 | Output sample strobe |
| out_i | output | 16 | Corrected I sample, signed |
| out_q | output | 16 | Corrected Q sample, signed |

## Verification
A control-word write and an integrator update can land on the same rail in the same clock. The bench provokes this by issuing writes that select tracking, freeze or load in the very cycle a valid sample arrives. It judges the result from the sample of that cycle, which must still carry the old offset, and from the samples that follow, which must show the written state with no tracking step folded in.

// File: rtl/dcoff_pkg.sv
package dcoff_pkg;

    parameter int SAMPLE_W  = 16;
    parameter int VALUE_W   = 30;
    parameter int LEAK_K    = 12;
    parameter int REG_W     = 32;
    parameter int ADDR_W    = 8;
    parameter int N_RAILS   = 2;

    localparam int FRAC_SH  = VALUE_W - SAMPLE_W;
    localparam int EST_W    = VALUE_W + 2;
    localparam int DIFF_W   = SAMPLE_W + 1;
    localparam int FIX_BIT  = REG_W - 1;
    localparam int SET_BIT  = REG_W - 2;

    typedef logic signed [SAMPLE_W-1:0] sample_t;
    typedef logic signed [EST_W-1:0]    est_t;

    typedef enum logic {
        TRACK = 1'b0,
        FROZEN = 1'b1
    } rail_mode_e;

    typedef struct packed {
        logic                 hit;
        logic                 fix;
        logic                 set;
        logic [VALUE_W-1:0]   value;
    } rail_cmd_t;

    function automatic sample_t clamp_sample(input logic signed [DIFF_W-1:0] d);
        logic signed [DIFF_W-1:0] hi;
        logic signed [DIFF_W-1:0] lo;
        hi = DIFF_W'((1 << (SAMPLE_W - 1)) - 1);
        lo = -DIFF_W'(1 << (SAMPLE_W - 1));
        if (d > hi)
            return sample_t'(hi);
        else if (d < lo)
            return sample_t'(lo);
        else
            return sample_t'(d);
    endfunction

    function automatic est_t widen_value(input logic [VALUE_W-1:0] v);
        return est_t'($signed(v));
    endfunction

endpackage

// File: rtl/dcoff_regdec.sv
module dcoff_regdec
    import dcoff_pkg::*;
#(
    parameter logic [ADDR_W-1:0] BASE_ADDR = 8'd8,
    parameter int                STRIDE    = 4
) (
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  wdata,
    output rail_cmd_t         cmd [N_RAILS]
);

    for (genvar r = 0; r < N_RAILS; r++) begin : g_rail
        localparam logic [ADDR_W-1:0] RAIL_ADDR = ADDR_W'(BASE_ADDR + r * STRIDE);
        always_comb begin
            cmd[r].hit   = wr && (addr == RAIL_ADDR);
            cmd[r].fix   = wdata[FIX_BIT];
            cmd[r].set   = wdata[SET_BIT];
            cmd[r].value = wdata[VALUE_W-1:0];
        end
    end

endmodule

// File: rtl/dcoff_rail.sv
module dcoff_rail
    import dcoff_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  rail_cmd_t  cmd,
    input  logic       smp_valid,
    input  sample_t    smp,
    output sample_t    offset,
    output rail_mode_e mode
);

    est_t est;
    est_t target;
    est_t step;

    always_comb begin
        target = est_t'(smp) <<< FRAC_SH;
        step   = (target - est) >>> LEAK_K;
        offset = sample_t'(est >>> FRAC_SH);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            est  <= '0;
            mode <= TRACK;
        end else if (cmd.hit) begin
            if (!cmd.fix) begin
                mode <= TRACK;
            end else begin
                mode <= FROZEN;
                if (cmd.set)
                    est <= widen_value(cmd.value);
            end
        end else if (smp_valid && mode == TRACK) begin
            est <= est + step;
        end
    end

    p_track_select_r5: assert property (@(posedge clk) disable iff (rst)
        (cmd.hit && !cmd.fix) |=> (mode == TRACK));

    p_freeze_holds_r6: assert property (@(posedge clk) disable iff (rst)
        (mode == FROZEN && !cmd.hit) |=> $stable(est));

    p_load_value_r7: assert property (@(posedge clk) disable iff (rst)
        (cmd.hit && cmd.fix && cmd.set) |=>
            (mode == FROZEN && est == widen_value($past(cmd.value))));

    p_idle_keeps_r10: assert property (@(posedge clk) disable iff (rst)
        (!smp_valid && !cmd.hit) |=> $stable(est));

endmodule

// File: rtl/dcoff_satsub.sv
module dcoff_satsub
    import dcoff_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    valid,
    input  sample_t x,
    input  sample_t offset,
    output sample_t y
);

    logic signed [DIFF_W-1:0] wide;
    localparam logic signed [DIFF_W-1:0] TOP = DIFF_W'((1 << (SAMPLE_W - 1)) - 1);

    always_comb wide = DIFF_W'(x) - DIFF_W'(offset);

    always_ff @(posedge clk) begin
        if (rst)
            y <= '0;
        else if (valid)
            y <= clamp_sample(wide);
    end

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
        (valid && wide > TOP) |=> (y == sample_t'(TOP)));

    p_no_underflow_r3: assert property (@(posedge clk) disable iff (rst)
        (valid && wide < -TOP - 1) |=> (y == sample_t'(-TOP - 1)));

endmodule

// File: rtl/rx_dc_corrector.sv
module rx_dc_corrector
    import dcoff_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [7:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    input  logic              in_valid,
    input  logic [15:0]       in_i,
    input  logic [15:0]       in_q,
    output logic              out_valid,
    output logic [15:0]       out_i,
    output logic [15:0]       out_q
);

    rail_cmd_t  cmd    [N_RAILS];
    sample_t    smp    [N_RAILS];
    sample_t    offs   [N_RAILS];
    sample_t    res    [N_RAILS];
    rail_mode_e mode   [N_RAILS];

    assign smp[0] = sample_t'(in_i);
    assign smp[1] = sample_t'(in_q);

    dcoff_regdec #(.BASE_ADDR(8'd8), .STRIDE(4)) u_dec (
        .wr    (reg_wr),
        .addr  (reg_addr),
        .wdata (reg_wdata),
        .cmd   (cmd)
    );

    for (genvar r = 0; r < N_RAILS; r++) begin : g_rail
        dcoff_rail u_rail (
            .clk       (clk),
            .rst       (rst),
            .cmd       (cmd[r]),
            .smp_valid (in_valid),
            .smp       (smp[r]),
            .offset    (offs[r]),
            .mode      (mode[r])
        );

        dcoff_satsub u_sub (
            .clk    (clk),
            .rst    (rst),
            .valid  (in_valid),
            .x      (smp[r]),
            .offset (offs[r]),
            .y      (res[r])
        );
    end

    always_ff @(posedge clk) begin
        if (rst)
            out_valid <= 1'b0;
        else
            out_valid <= in_valid;
    end

    assign out_i = res[0];
    assign out_q = res[1];

    p_valid_follows_r2: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    p_valid_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

endmodule

// File: tb/tb_rx_dc_corrector.sv
`timescale 1ns/100ps
module tb_rx_dc_corrector;

    logic        clk = 1'b0;
    logic        rst;
    logic        reg_wr;
    logic [7:0]  reg_addr;
    logic [31:0] reg_wdata;
    logic        in_valid;
    logic [15:0] in_i;
    logic [15:0] in_q;
    logic        out_valid;
    logic [15:0] out_i;
    logic [15:0] out_q;

    always #2.5 clk = ~clk;

    rx_dc_corrector dut (
        .clk(clk), .rst(rst),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .in_valid(in_valid), .in_i(in_i), .in_q(in_q),
        .out_valid(out_valid), .out_i(out_i), .out_q(out_q)
    );

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    longint est_m  [2];
    int     mode_m [2];

    int    q_i   [$];
    int    q_q   [$];
    string q_tag [$];

    function automatic int sat16(input longint d);
        if (d > 32767) return 32767;
        if (d < -32768) return -32768;
        return int'(d);
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Driver: applies one cycle of stimulus and advances the model.
    task automatic step(input bit wr, input logic [7:0] addr, input logic [31:0] data,
                        input bit v, input int xi, input int xq, input string tag);
        longint x [2];
        int     e [2];
        bit     hit [2];
        @(negedge clk);
        reg_wr    = wr;
        reg_addr  = addr;
        reg_wdata = data;
        in_valid  = v;
        in_i      = 16'(xi);
        in_q      = 16'(xq);
        x[0] = xi;
        x[1] = xq;
        hit[0] = wr && addr == 8'd8;
        hit[1] = wr && addr == 8'd12;
        for (int r = 0; r < 2; r++) begin
            if (v) e[r] = sat16(x[r] - (est_m[r] >>> 14));
            if (v && mode_m[r] == 0 && !hit[r])
                est_m[r] = est_m[r] + (((x[r] <<< 14) - est_m[r]) >>> 12);
            if (hit[r]) begin
                if (!data[31]) mode_m[r] = 0;
                else begin
                    mode_m[r] = 1;
                    if (data[30])
                        est_m[r] = data[29] ? longint'(data[29:0]) - (longint'(1) << 30)
                                            : longint'(data[29:0]);
                end
            end
        end
        if (v) begin
            q_i.push_back(e[0]);
            q_q.push_back(e[1]);
            q_tag.push_back(tag);
        end
    endtask

    // Monitor: pops expectations as the design produces samples.
    always @(negedge clk) begin
        if (!rst && out_valid) begin
            if (q_i.size() == 0) begin
                total++;
                bad++;
                $display("FAIL R2 actual=unexpected_output expected=no_output");
            end else begin
                string t;
                int ei, eq;
                ei = q_i.pop_front();
                eq = q_q.pop_front();
                t  = q_tag.pop_front();
                check({t, " I"}, int'($signed(out_i)), ei);
                check({t, " Q"}, int'($signed(out_q)), eq);
            end
        end
    end

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; reg_wr = 0; reg_addr = 0; reg_wdata = 0;
        in_valid = 0; in_i = 0; in_q = 0;
        for (int r = 0; r < 2; r++) begin est_m[r] = 0; mode_m[r] = 0; end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state at the ports
        check("R1 out_valid", int'(out_valid), 0);
        check("R1 out_i", int'($signed(out_i)), 0);
        check("R1 out_q", int'($signed(out_q)), 0);
        step(0, 0, 0, 1, 1000, -1000, "R1");

        // R4: tracking on constant inputs
        for (int n = 0; n < 300; n++) step(0, 0, 0, 1, 8000, -4000, "R4");
        // R2 and R10: gaps in the stream
        for (int n = 0; n < 40; n++) step(0, 0, 0, n % 3 == 0, 12000 - n * 100, n * 50, "R10");
        for (int n = 0; n < 60; n++) step(0, 0, 0, 1, (n % 2) ? 20000 : -20000, 3000, "R4");

        // R6: freeze I, Q keeps tracking
        step(1, 8'd8, 32'h8000_0000, 0, 0, 0, "R6");
        for (int n = 0; n < 40; n++) step(0, 0, 0, 1, n * 700 - 10000, 5000, "R6");

        // R7 and R3: load extreme offsets
        step(1, 8'd8,  32'hC000_0000 | 32'h1FFF_FFFF, 0, 0, 0, "R7");
        step(1, 8'd12, 32'hC000_0000 | 32'h2000_0000, 0, 0, 0, "R7");
        step(0, 0, 0, 1, -32768, 32767, "R3");
        step(0, 0, 0, 1, 0, 0, "R7");
        step(0, 0, 0, 1, 32767, -32768, "R3");
        step(1, 8'd8, 32'hC000_0000 | 32'h0123_4567, 1, 300, -300, "R7");
        step(0, 0, 0, 1, 300, -300, "R7");

        // R8: other addresses do nothing
        step(1, 8'd16, 32'hC000_0000, 1, 100, 100, "R8");
        step(1, 8'd4,  32'h0000_0000, 1, 100, 100, "R8");
        step(1, 8'd0,  32'hC000_0000, 1, 100, 100, "R8");
        for (int n = 0; n < 5; n++) step(0, 0, 0, 1, 4000, -4000, "R8");

        // R5: back to tracking with ignored set flag and value bits
        step(1, 8'd8, 32'h7FFF_FFFF, 0, 0, 0, "R5");
        for (int n = 0; n < 30; n++) step(0, 0, 0, 1, 6000, -6000, "R5");

        // R9: writes colliding with valid samples
        step(1, 8'd12, 32'h8000_0000, 1, 6000, -6000, "R9");
        step(0, 0, 0, 1, 6000, 9000, "R9");
        step(1, 8'd8, 32'hC000_0000 | 32'h0040_0000, 1, 7000, 9000, "R9");
        step(0, 0, 0, 1, 7000, 9000, "R9");
        step(1, 8'd12, 32'h0000_0000, 1, -7000, 9000, "R9");
        for (int n = 0; n < 10; n++) step(0, 0, 0, 1, -7000, 9000, "R9");

        step(0, 0, 0, 0, 0, 0, "R2");
        repeat (3) @(negedge clk);
        check("R2 drained", q_i.size(), 0);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule